// File: doc/BRIEF.md
# Ping-Pong Buffered PWM Timer

This block produces one pulse-width-modulated output from a 16-bit up-counter. The counter counts from zero up to a programmable period value and then wraps to zero. A prescaler sets how often the counter advances. Two compare registers, A and B, supply the pulse width. Without linking, only compare A is used, and a new value in A changes the pulse width at once.

When the link bit is set, A and B form one double-buffered channel. Software writes the register that is not active. The new width then takes over cleanly at the next counter wrap, so no period is ever cut short. The pin normally used by the second channel is reported as free for general-purpose use.

Software reaches the block through a single-cycle write port with four word-wide registers, so a value is never used half-written. The control word holds four fields:
- a stop bit that freezes counting;
- a self-clearing clear bit that zeroes the counter and the prescaler;
- the link bit;
- the prescaler select.

Top module: `pingpong_pwm`

## Requirements
- R1: After reset the counter is stopped and at zero, the period register is all ones, both compare registers are zero, the link bit is clear, `pwm_out` is low and `aux_pin_free` is low.
- R2: While running, the counter advances once per prescaler tick. On a tick where the count is greater than or equal to the period value, the count goes to zero instead; this is the overflow. A period therefore lasts period+1 ticks.
- R3: `pwm_out` is high exactly while the count is below the active compare value. A compare value above the period value gives a constant high, and zero gives a constant low.
- R4: Control bit 2 is the link bit. `aux_pin_free` follows it one cycle after the write. On linking, compare A is the active source.
- R5: While linked, a write to the inactive compare register does not change the output before the next overflow. From that overflow on, the written register is active.
- R6: While linked, each overflow makes active whichever of A or B was written most recently. This includes a write in the overflow cycle itself. If both are written within one period, the later write decides.
- R7: A write to the currently active compare register changes the pulse width from the next cycle, without waiting for an overflow.
- R8: While unlinked, writes to compare B (address 3) have no effect on `pwm_out`.
- R9: Control bit 0 is the stop bit. While it is set, the counter and the prescaler hold their values, and no overflow or swap happens.
- R10: Writing control with bit 1 set clears the counter and the prescaler on that clock edge, with no overflow. The bit is not stored.
- R11: Control bits 5:3 hold the prescaler select n. The counter then advances once every 2^n clock cycles.
- R12: The register addresses are: 0 for control, 1 for the period, 2 for compare A and 3 for compare B. Each write takes the whole 16-bit word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address (0 control, 1 period, 2 compare A, 3 compare B) |
| wr_data | input | 16 | Write data |
| pwm_out | output | 1 | PWM output |
| aux_pin_free | output | 1 | High while linked: second channel pin available for general use |

## Verification
The bench keeps the default 16-bit data width and the 3-bit prescaler select. It programs short periods of ten ticks, so that many overflows, and therefore many buffer swaps, fit into a short run. Prescaler selects 0 and 2 show both single-cycle ticks and divided ticks. The small period also puts the over-period and zero compare values, and back-to-back writes to both compare registers within one period, within a few dozen cycles.

// File: rtl/ppwm_pkg.sv
package ppwm_pkg;

    typedef enum logic [1:0] {
        RA_CTRL  = 2'd0,
        RA_MOD   = 2'd1,
        RA_CMP_A = 2'd2,
        RA_CMP_B = 2'd3
    } reg_addr_e;

    localparam int CB_STOP   = 0;
    localparam int CB_CLEAR  = 1;
    localparam int CB_LINK   = 2;
    localparam int CB_PS_LSB = 3;

    typedef struct packed {
        logic sel;   // 0: compare A active, 1: compare B active
        logic last;  // register written most recently
    } duty_state_t;

endpackage

// File: rtl/ppwm_prescaler.sv
module ppwm_prescaler #(
    parameter int PS_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic            clear,
    input  logic [PS_W-1:0] div_sel,
    output logic            tick
);
    localparam int DIV_W = (1 << PS_W) - 1;

    logic [DIV_W-1:0] div_q, div_d;
    logic [DIV_W-1:0] mask;

    always_comb begin
        mask = ~({DIV_W{1'b1}} << div_sel);
        tick = run && ((div_q & mask) == mask);
        div_d = div_q;
        if (clear) begin
            div_d = '0;
        end else if (run) begin
            div_d = div_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
        end else begin
            div_q <= div_d;
        end
    end
endmodule

// File: rtl/ppwm_counter.sv
module ppwm_counter #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          clear,
    input  logic [DW-1:0] period,
    output logic [DW-1:0] count,
    output logic          wrap
);
    logic [DW-1:0] cnt_q, cnt_d;

    always_comb begin
        wrap  = tick && !clear && (cnt_q >= period);
        cnt_d = cnt_q;
        if (clear || wrap) begin
            cnt_d = '0;
        end else if (tick) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign count = cnt_q;
endmodule

// File: rtl/ppwm_duty_sel.sv
module ppwm_duty_sel
    import ppwm_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          linked,
    input  logic          wrap,
    input  logic          wr_a,
    input  logic          wr_b,
    input  logic [DW-1:0] cmp_a,
    input  logic [DW-1:0] cmp_b,
    output logic [DW-1:0] cmp_active,
    output logic          sel
);
    duty_state_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (!linked) begin
            st_d.sel  = 1'b0;
            st_d.last = 1'b0;
        end else begin
            if (wr_a) st_d.last = 1'b0;
            if (wr_b) st_d.last = 1'b1;
            if (wrap) st_d.sel  = st_d.last;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sel        = st_q.sel;
    assign cmp_active = st_q.sel ? cmp_b : cmp_a;
endmodule

// File: rtl/pingpong_pwm.sv
module pingpong_pwm
    import ppwm_pkg::*;
#(
    parameter int DW   = 16,
    parameter int PS_W = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [1:0]    wr_addr,
    input  logic [DW-1:0] wr_data,
    output logic          pwm_out,
    output logic          aux_pin_free
);
    typedef struct packed {
        logic            stop;
        logic            link;
        logic [PS_W-1:0] psel;
        logic [DW-1:0]   period;
        logic [DW-1:0]   cmp_a;
        logic [DW-1:0]   cmp_b;
    } regs_t;

    regs_t r_q, r_d;

    logic          wr_ctrl, wr_mod, wr_a, wr_b, clr_w;
    logic          tick_w, wrap_w, sel_w;
    logic [DW-1:0] cnt_w, cmp_act_w;

    always_comb begin
        wr_ctrl = wr_en && (wr_addr == RA_CTRL);
        wr_mod  = wr_en && (wr_addr == RA_MOD);
        wr_a    = wr_en && (wr_addr == RA_CMP_A);
        wr_b    = wr_en && (wr_addr == RA_CMP_B);
        clr_w   = wr_ctrl && wr_data[CB_CLEAR];

        r_d = r_q;
        if (wr_ctrl) begin
            r_d.stop = wr_data[CB_STOP];
            r_d.link = wr_data[CB_LINK];
            r_d.psel = wr_data[CB_PS_LSB +: PS_W];
        end
        if (wr_mod) r_d.period = wr_data;
        if (wr_a)   r_d.cmp_a  = wr_data;
        if (wr_b)   r_d.cmp_b  = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.stop   <= 1'b1;
            r_q.link   <= 1'b0;
            r_q.psel   <= '0;
            r_q.period <= '1;
            r_q.cmp_a  <= '0;
            r_q.cmp_b  <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    ppwm_prescaler #(.PS_W(PS_W)) u_presc (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (!r_q.stop),
        .clear   (clr_w),
        .div_sel (r_q.psel),
        .tick    (tick_w)
    );

    ppwm_counter #(.DW(DW)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick_w),
        .clear  (clr_w),
        .period (r_q.period),
        .count  (cnt_w),
        .wrap   (wrap_w)
    );

    ppwm_duty_sel #(.DW(DW)) u_duty (
        .clk        (clk),
        .rst_n      (rst_n),
        .linked     (r_q.link),
        .wrap       (wrap_w),
        .wr_a       (wr_a),
        .wr_b       (wr_b),
        .cmp_a      (r_q.cmp_a),
        .cmp_b      (r_q.cmp_b),
        .cmp_active (cmp_act_w),
        .sel        (sel_w)
    );

    assign pwm_out      = (cnt_w < cmp_act_w);
    assign aux_pin_free = r_q.link;
endmodule

// File: rtl/pingpong_pwm_chk.sv
module pingpong_pwm_chk #(
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          stop,
    input logic          linked,
    input logic          tick,
    input logic          wrap,
    input logic          clr,
    input logic          sel,
    input logic [DW-1:0] cnt,
    input logic [DW-1:0] period,
    input logic [DW-1:0] cmp_act,
    input logic          pwm_out
);
    // R2: an overflow tick returns the count to zero
    a_r2_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> (cnt == '0));

    // R9: a stopped counter holds unless cleared
    a_r9_stop_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (stop && !clr) |=> $stable(cnt));

    // R10: a clear write empties the counter
    a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt == '0));

    // R5: while linked, the active source changes only at an overflow
    a_r5_no_early_swap: assert property (@(posedge clk) disable iff (!rst_n)
        (linked && !wrap) |=> $stable(sel));

    // R8: unlinked, compare A is the source
    a_r8_unlinked_a: assert property (@(posedge clk) disable iff (!rst_n)
        !linked |=> !sel);

    // R3: a compare value above the period keeps the output high
    a_r3_const_high: assert property (@(posedge clk) disable iff (!rst_n)
        ((cmp_act > period) && (cnt <= period)) |-> pwm_out);

    // R9: no tick is produced while stopped
    a_r9_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
        stop |-> !tick);
endmodule

bind pingpong_pwm pingpong_pwm_chk #(.DW(DW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .stop    (r_q.stop),
    .linked  (r_q.link),
    .tick    (tick_w),
    .wrap    (wrap_w),
    .clr     (clr_w),
    .sel     (sel_w),
    .cnt     (cnt_w),
    .period  (r_q.period),
    .cmp_act (cmp_act_w),
    .pwm_out (pwm_out)
);

// File: tb/pingpong_pwm_test.sv
module pingpong_pwm_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = 2'd0;
    logic [15:0] wr_data = 16'd0;
    logic        pwm_out, aux_pin_free;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    string cur_req = "R1";
    bit live = 1'b0;

    // behavioural reference state
    int m_cnt, m_ps, m_per, m_a, m_b, m_psel;
    bit m_stop, m_link, m_sel, m_last;

    always #10 clk = ~clk;

    pingpong_pwm uut (
        .clk (clk), .rst_n (rst_n), .wr_en (wr_en), .wr_addr (wr_addr),
        .wr_data (wr_data), .pwm_out (pwm_out), .aux_pin_free (aux_pin_free)
    );

    function automatic bit m_pwm();
        return m_cnt < (m_sel ? m_b : m_a);
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_cnt = 0; m_ps = 0; m_per = 65535; m_a = 0; m_b = 0; m_psel = 0;
            m_stop = 1; m_link = 0; m_sel = 0; m_last = 0;
        end else begin
            bit clr, tk, ov, nl;
            int msk;
            clr = wr_en && wr_addr == 0 && wr_data[1];
            msk = (1 << m_psel) - 1;
            tk  = !m_stop && ((m_ps & msk) == msk);
            ov  = tk && !clr && (m_cnt >= m_per);
            if (!m_link) begin
                m_sel = 0; m_last = 0;
            end else begin
                if (wr_en && wr_addr == 2) m_last = 0;
                if (wr_en && wr_addr == 3) m_last = 1;
                if (ov) m_sel = m_last;
            end
            if (clr) m_ps = 0;
            else if (!m_stop) m_ps = (m_ps + 1) % 128;
            if (clr || ov) m_cnt = 0;
            else if (tk) m_cnt = (m_cnt + 1) & 16'hFFFF;
            if (wr_en) begin
                case (wr_addr)
                    2'd0: begin
                        m_stop = wr_data[0]; nl = wr_data[2];
                        m_link = nl; m_psel = int'(wr_data[5:3]);
                    end
                    2'd1: m_per = int'(wr_data);
                    2'd2: m_a = int'(wr_data);
                    default: m_b = int'(wr_data);
                endcase
            end
        end
    end

    task automatic check(input bit act, input bit exp, input string req, input string what);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %0b expected %0b at cycle %0d", req, what, act, exp, cyc);
        end
    endtask

    always @(negedge clk) begin
        cyc++;
        if (live) begin
            check(pwm_out, m_pwm(), cur_req, "pwm_out");
            check(aux_pin_free, m_link, cur_req, "aux_pin_free");
        end
    end

    task automatic wr(input int a, input int d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 2'(a); wr_data = 16'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic duty(input int cycles, input int exp, input string req);
        int hi = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (pwm_out) hi++;
        end
        n_cmp++;
        if (hi != exp) begin
            n_bad++;
            $display("FAIL %s high count: got %0d expected %0d", req, hi, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        int ctl_link;
        ctl_link = 4;
        repeat (3) @(negedge clk);
        // R1: reset values at the ports
        check(pwm_out, 1'b0, "R1", "reset pwm_out");
        check(aux_pin_free, 1'b0, "R1", "reset aux_pin_free");
        rst_n = 1'b1;
        live = 1'b1;
        repeat (4) @(negedge clk);

        // R12 R2 R3: period 10, width 4, running unlinked
        cur_req = "R12";
        wr(1, 9);
        wr(2, 4);
        cur_req = "R2";
        wr(0, 0);
        repeat (12) @(negedge clk);
        duty(50, 20, "R2");
        cur_req = "R3";
        wr(2, 12);
        repeat (12) @(negedge clk);
        duty(30, 30, "R3");
        wr(2, 0);
        repeat (2) @(negedge clk);
        duty(30, 0, "R3");

        // R8: B writes ignored when unlinked
        cur_req = "R8";
        wr(2, 4);
        wr(3, 7);
        repeat (12) @(negedge clk);
        duty(30, 12, "R8");

        // R4: linking, A active first
        cur_req = "R4";
        wr(0, ctl_link);
        check(aux_pin_free, 1'b1, "R4", "aux_pin_free after link");
        repeat (12) @(negedge clk);
        duty(30, 12, "R4");

        // R5: inactive write deferred to overflow
        cur_req = "R5";
        wr(3, 8);
        repeat (12) @(negedge clk);
        duty(30, 24, "R5");

        // R6: both written in one period, later wins
        cur_req = "R6";
        wr(2, 2);
        wr(3, 6);
        repeat (12) @(negedge clk);
        duty(30, 18, "R6");
        wr(3, 1);
        wr(2, 3);
        repeat (12) @(negedge clk);
        duty(30, 9, "R6");

        // R7: active register write takes effect without swap
        cur_req = "R7";
        wr(2, 5);
        repeat (12) @(negedge clk);
        duty(30, 15, "R7");

        // R9: stop holds output
        cur_req = "R9";
        wr(0, ctl_link | 1);
        repeat (25) @(negedge clk);

        // R10: clear while stopped zeroes count, output high
        cur_req = "R10";
        wr(0, ctl_link | 1 | 2);
        check(pwm_out, 1'b1, "R10", "pwm_out after clear");
        wr(0, ctl_link);
        repeat (12) @(negedge clk);

        // R11: prescale by 4 gives period of 40 clocks, 20 high
        cur_req = "R11";
        wr(0, ctl_link | (2 << 3));
        repeat (45) @(negedge clk);
        duty(80, 40, "R11");

        live = 1'b0;
        finish_run();
    end
endmodule